// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block sequences the operating mode of a single-wire bus transceiver. It tracks four modes (unpowered, standby, normal and sleep) and from the present mode and the way it was reached it produces every pin configuration the analog front end needs: the inhibit switch that powers an external regulator, the transmitter enable, the bus termination choice, the drive on the receive pin and the strength of the pull-down on the transmit pin.

Its inputs are a supply-below-reset flag, the raw enable pin and a one-cycle wake strobe with a flag giving its source (local switch or bus). A separate detector supplies the wake strobes. The enable pin is glitch-filtered here by two cycle counters, one for entering normal mode and one for entering sleep. After a wake-up the controller reports the wake source to the host through the receive pin (driven low) and the transmit pull-down (strong for a local wake). The host clears this reporting as soon as it raises enable, without waiting for the filter.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: Whenever `supply_low` is 1 at a clock edge, `mode` is 0 (unpowered) after that edge. In unpowered mode `inh_on`=0, `term_sel`=0 (floating), `rx_drive`=0 (floating) and `tx_pd_strong`=0. Asynchronous reset also gives this state.
- R2: From unpowered, the first edge with `supply_low`=0 moves to standby (`mode`=1) with `inh_on`=1, `rx_drive`=0 and `tx_pd_strong`=0.
- R3: In sleep (`mode`=3), a `wake_stb` edge moves to standby with `rx_drive`=2 (held low). `tx_pd_strong` is 1 when `wake_local`=1 and 0 when it is 0. A wake wins over a completing enable filter in the same cycle.
- R4: In standby, further wake strobes change neither `rx_drive` nor `tx_pd_strong`.
- R5: From standby or sleep, `mode` becomes 2 (normal) after `en_pin` has been sampled high on EN_CYC consecutive edges. A shorter high pulse leaves the mode unchanged.
- R6: In standby, `rx_drive` returns to 0 and `tx_pd_strong` to 0 in the same cycle that `en_pin` is 1, before the filter expires. The release stays in force until standby is left.
- R7: From normal, `mode` becomes 3 (sleep) after `en_pin` has been sampled low on DIS_CYC consecutive edges. A shorter low pulse leaves normal mode in place.
- R8: In normal mode with `en_pin`=0 (the sleep filter window), a wake strobe moves to standby with the wake pin settings of R3. With `en_pin`=1 a wake strobe is ignored.
- R9: Normal mode gives `xcvr_on`=1, `inh_on`=1, `term_sel`=1 (resistor) and `rx_drive`=1 (bus data). Standby gives `term_sel`=1. Sleep gives `term_sel`=2 (current source), `inh_on`=0 and `rx_drive`=0. `xcvr_on` is 0 outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low | input | 1 | Supply is below the power-on reset level |
| en_pin | input | 1 | Raw enable pin |
| wake_stb | input | 1 | One-cycle wake event strobe |
| wake_local | input | 1 | Wake source: 1 local switch, 0 bus |
| mode | output | 2 | 0 unpowered, 1 standby, 2 normal, 3 sleep |
| inh_on | output | 1 | Inhibit switch closed |
| xcvr_on | output | 1 | Transmitter and receiver active |
| term_sel | output | 2 | 0 floating, 1 resistor, 2 current source |
| rx_drive | output | 2 | 0 floating, 1 bus data, 2 held low |
| tx_pd_strong | output | 1 | Transmit pin pull-down strong when 1 |

## Verification
The bench probes both filter boundaries with pulses one cycle short and exactly long enough. A counter that is off by one would either switch modes too early or miss a legal request. It checks that raising enable in standby releases the wake reporting in the same cycle and that the release survives enable dropping again. A design that waited for the filter would let the host's drive fight the strong pull-down. It injects wakes during the sleep window, while enable is high in normal mode, and while already in standby. A design that misclassified these would lose a genuine wake, report a spurious one, or overwrite the reported source.

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl #(
  parameter int EN_CYC  = 400,
  parameter int DIS_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low,
  input  logic       en_pin,
  input  logic       wake_stb,
  input  logic       wake_local,
  output logic [1:0] mode,
  output logic       inh_on,
  output logic       xcvr_on,
  output logic [1:0] term_sel,
  output logic [1:0] rx_drive,
  output logic       tx_pd_strong
);
  localparam int MAXC = (EN_CYC > DIS_CYC) ? EN_CYC : DIS_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] EN_LAST  = CW'(EN_CYC - 1);
  localparam logic [CW-1:0] DIS_LAST = CW'(DIS_CYC - 1);

  typedef enum logic [1:0] {M_OFF = 2'd0, M_STBY = 2'd1, M_NORM = 2'd2, M_SLEEP = 2'd3} mode_t;
  localparam logic [1:0] T_FLOAT = 2'd0, T_RES = 2'd1, T_CSRC = 2'd2;
  localparam logic [1:0] RX_FLOAT = 2'd0, RX_DATA = 2'd1, RX_LOW = 2'd2;

  mode_t          st, st_nx;
  logic [CW-1:0]  cnt;
  logic           wk_q, loc_q, rel_q;
  logic           want, done, woke;

  assign want = (st == M_NORM) ? !en_pin : en_pin;
  assign done = want && (cnt == ((st == M_NORM) ? DIS_LAST : EN_LAST));
  assign woke = wake_stb && ((st == M_SLEEP) || (st == M_NORM && !en_pin));

  always_comb begin
    st_nx = st;
    if (supply_low) st_nx = M_OFF;
    else begin
      case (st)
        M_OFF:   st_nx = M_STBY;
        M_STBY:  if (done) st_nx = M_NORM;
        M_SLEEP: if (woke) st_nx = M_STBY; else if (done) st_nx = M_NORM;
        M_NORM:  if (woke) st_nx = M_STBY; else if (done) st_nx = M_SLEEP;
        default: st_nx = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_OFF;
      cnt <= '0;
      wk_q <= 1'b0;
      loc_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st || !want || st == M_OFF) cnt <= '0;
      else if (cnt != CW'(MAXC)) cnt <= cnt + 1'b1;
      if (st_nx == M_STBY && st != M_STBY) begin
        wk_q  <= woke;
        loc_q <= woke && wake_local;
        rel_q <= 1'b0;
      end else if (st == M_STBY && en_pin) begin
        rel_q <= 1'b1;
      end
    end
  end

  logic held;
  assign held = (st == M_STBY) && !(rel_q || en_pin);

  assign mode         = st;
  assign inh_on       = (st == M_STBY) || (st == M_NORM);
  assign xcvr_on      = (st == M_NORM);
  assign term_sel     = (st == M_OFF) ? T_FLOAT : (st == M_SLEEP) ? T_CSRC : T_RES;
  assign rx_drive     = (st == M_NORM) ? RX_DATA : (held && wk_q) ? RX_LOW : RX_FLOAT;
  assign tx_pd_strong = held && loc_q;

  assert_unpowered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (mode == 2'd0 && !inh_on && term_sel == 2'd0 && rx_drive == 2'd0 && !tx_pd_strong));

  assert_powerup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !supply_low) |=> (mode == 2'd1 && inh_on && rx_drive == 2'd0 && !tx_pd_strong));

  assert_sleep_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && wake_stb && !supply_low) |=> (mode == 2'd1 && (en_pin || rx_drive == 2'd2)));

  assert_stby_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !supply_low && !en_pin) |=> (en_pin || ($stable(rx_drive) && $stable(tx_pd_strong))));

  assert_norm_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2) |=> (mode != 2'd2 || $past(en_pin)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && en_pin) |-> (rx_drive == 2'd0 && !tx_pd_strong));

  assert_sleep_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode != 2'd3 || !$past(en_pin)));

  assert_norm_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (xcvr_on && inh_on && term_sel == 2'd1 && rx_drive == 2'd1));
endmodule

// File: tb/xcvr_mode_ctrl_test.sv
module xcvr_mode_ctrl_test;
  localparam int EN_C  = 12;
  localparam int DIS_C = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_low = 1'b1, en_pin = 1'b0, wake_stb = 1'b0, wake_local = 1'b0;
  logic [1:0] mode, term_sel, rx_drive;
  logic inh_on, xcvr_on, tx_pd_strong;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  xcvr_mode_ctrl #(.EN_CYC(EN_C), .DIS_CYC(DIS_C)) uut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .en_pin(en_pin),
    .wake_stb(wake_stb), .wake_local(wake_local), .mode(mode), .inh_on(inh_on),
    .xcvr_on(xcvr_on), .term_sel(term_sel), .rx_drive(rx_drive), .tx_pd_strong(tx_pd_strong));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input string req, input int m, input int inh, input int xo,
                      input int term, input int rx, input int pd);
    chk({req, " mode"}, mode, m);
    chk({req, " inh"}, inh_on, inh);
    chk({req, " xcvr"}, xcvr_on, xo);
    chk({req, " term"}, term_sel, term);
    chk({req, " rx"}, rx_drive, rx);
    chk({req, " txpd"}, tx_pd_strong, pd);
  endtask

  task automatic wake(input logic loc);
    wake_local = loc; wake_stb = 1'b1;
    step(1);
    wake_stb = 1'b0; wake_local = 1'b0;
  endtask

  task automatic go_normal();
    en_pin = 1'b1;
    step(EN_C);
  endtask

  task automatic go_sleep();
    en_pin = 1'b0;
    step(DIS_C);
  endtask

  task automatic t_reset_R1();
    step(2);
    pins("R1 reset", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    step(3);
    pins("R1 supply low", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_powerup_R2();
    supply_low = 1'b0;
    step(1);
    pins("R2 powerup standby", 1, 1, 0, 1, 0, 0);
  endtask

  task automatic t_enable_filter_R5();
    en_pin = 1'b1; step(EN_C - 1); en_pin = 1'b0; step(1);
    chk("R5 short pulse stays standby", mode, 1);
    go_normal();
    pins("R9 normal pins", 2, 1, 1, 1, 1, 0);
  endtask

  task automatic t_sleep_filter_R7();
    en_pin = 1'b0; step(DIS_C - 1); en_pin = 1'b1; step(1);
    chk("R7 short low stays normal", mode, 2);
    go_sleep();
    pins("R7 R9 sleep pins", 3, 0, 0, 2, 0, 0);
  endtask

  task automatic t_local_wake_R3();
    wake(1'b1);
    pins("R3 local wake", 1, 1, 0, 1, 2, 1);
  endtask

  task automatic t_ignore_R4();
    wake(1'b0);
    step(2);
    chk("R4 rx after extra wake", rx_drive, 2);
    chk("R4 txpd after extra wake", tx_pd_strong, 1);
  endtask

  task automatic t_release_R6();
    en_pin = 1'b1; #1;
    chk("R6 rx released at once", rx_drive, 0);
    chk("R6 txpd weak at once", tx_pd_strong, 0);
    chk("R6 still standby", mode, 1);
    step(3); en_pin = 1'b0; step(2);
    chk("R6 release sticky rx", rx_drive, 0);
    chk("R6 release sticky txpd", tx_pd_strong, 0);
    go_normal();
    chk("R5 normal from standby", mode, 2);
  endtask

  task automatic t_bus_wake_R3();
    go_sleep();
    wake(1'b0);
    pins("R3 bus wake", 1, 1, 0, 1, 2, 0);
    go_normal();
  endtask

  task automatic t_window_R8();
    en_pin = 1'b1;
    wake(1'b1);
    chk("R8 wake with en high ignored", mode, 2);
    en_pin = 1'b0; step(3);
    wake(1'b1);
    pins("R8 wake in window", 1, 1, 0, 1, 2, 1);
    go_normal();
    go_sleep();
    en_pin = 1'b1; step(EN_C - 1);
    wake(1'b0);
    chk("R3 wake beats enable", mode, 1);
    chk("R3 wake beats enable rx", rx_drive, 0);
    step(EN_C);
    chk("R5 normal after wake", mode, 2);
  endtask

  task automatic t_drop_R1();
    supply_low = 1'b1; step(1);
    pins("R1 drop from normal", 0, 0, 0, 0, 0, 0);
    supply_low = 1'b0; en_pin = 1'b0; step(1);
    pins("R2 repowered", 1, 1, 0, 1, 0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_R1();
        t_powerup_R2();
        t_enable_filter_R5();
        t_sleep_filter_R7();
        t_local_wake_R3();
        t_ignore_R4();
        t_release_R6();
        t_bus_wake_R3();
        t_window_R8();
        t_drop_R1();
      end
      begin
        step(20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule